// File: doc/BRIEF.md
# Configurable Pseudo Dual-Port RAM

This block is one fixed 16,384-bit storage array with a write side and a separate read side. Each side has its own clock and its own clock enable, and the two clocks may be unrelated. A parameter sets the word width at elaboration time. The address width then follows so that the array always holds 16,384 bits.

Every write-side input is captured in a register on the write clock. Those are the address, the data, the write enable and a two-bit select. The captured write lands in the array on the next enabled write edge. It lands only if the captured enable is high and the captured select equals a parameterised code.

On the read side, two parameters decide separately whether the read address and the read data are registered on the read clock or pass straight through. One asynchronous reset clears the port registers and leaves the stored words unchanged. That reset is the OR of a global reset pin and a local reset pin.

The ports are plain pins with no valid/ready handshake. Every write is accepted, with no back-pressure, once it is captured on an enabled write edge. Every read returns data after a fixed latency of registered stages.

Top module: `pdpr_top`

## Requirements
- R1: The array holds 16,384 bits for every `DATA_W` in {1, 2, 4, 8, 16, 32}. The address width is log2(16384/`DATA_W`): 11 bits at width 8 and 9 bits at width 32. The highest address and address 0 are distinct words.
- R2: A write presented on one enabled write edge is committed to the array on the next enabled write edge. A later read of that address returns the written word.
- R3: A write commits only when the captured `wr_sel` equals `SEL_CODE`, which defaults to 2'b10. With select values 2'b01 or 2'b11 the array is left unchanged.
- R4: When the captured `wr_en` is low, the array is left unchanged.
- R5: While `wr_ce` is low, the write-side registers hold their values and the write inputs are ignored.
- R6: While `rd_ce` is low, the read-side registers hold their values, so `rd_data` does not follow `rd_addr`.
- R7: With a shared clock, a read and a commit to the same address on the same edge return the old word. The next read returns the new word.
- R8: While reset is active, the registered `rd_data` is 0. The stored words survive reset.
- R9: The effective reset is `glob_rst` OR `loc_rst`, and either pin alone causes it.
- R10: A write that was captured but not yet committed is dropped if reset arrives before its commit edge.
- R11: In the default mode (registered data, pass-through address), `rd_data` shows the word at the `rd_addr` that was sampled on the last enabled read edge.
- R12: In registered-address, pass-through-data mode, the address is sampled on the read edge and `rd_data` then follows the array combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glob_rst | input | 1 | Global asynchronous reset, active high |
| loc_rst | input | 1 | Local asynchronous reset, active high |
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Write select, compared with SEL_CODE |
| wr_addr | input | AW | Write word address |
| wr_data | input | DATA_W | Write word |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read-side clock enable |
| rd_addr | input | AW | Read word address |
| rd_data | output | DATA_W | Read word |

## Verification
The array is filled with an address-dependent ramp, with the complementary words 0x55/0xAA and 0x00/0xFF, and at address 0 and the top address. This separates correct storage from stuck bits, swapped data lines and address aliasing. Writes are repeated with a wrong select code, with the enable low and with the clock enable low. Reset pulses on each reset pin alone land between capture and commit. Together these show which of the three gating conditions and the reset path actually block a commit. A read and a commit to the same address on one edge, followed by a second read, tells the old word from the new one. A second instance at 32 bits with a registered address and pass-through data checks the other read mode.

// File: rtl/pdpr_pkg.sv
`timescale 1ns/1ps
package pdpr_pkg;
  localparam int ARRAY_BITS = 16384;

  function automatic int addr_bits(input int dw);
    return $clog2(ARRAY_BITS / dw);
  endfunction

  function automatic bit width_ok(input int dw);
    return (dw == 1) || (dw == 2) || (dw == 4) || (dw == 8) || (dw == 16) || (dw == 32);
  endfunction
endpackage

// File: rtl/pdpr_rst_or.sv
`timescale 1ns/1ps
module pdpr_rst_or (
  input  logic glob_rst,
  input  logic loc_rst,
  output logic rst
);
  assign rst = glob_rst | loc_rst;
endmodule

// File: rtl/pdpr_wr_stage.sv
`timescale 1ns/1ps
module pdpr_wr_stage #(
  parameter int DW = 8,
  parameter int AW = 11,
  parameter logic [1:0] SEL_CODE = 2'b10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          commit,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  logic       en_q;
  logic [1:0] sel_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= 2'b00;
      addr_q <= '0;
      data_q <= '0;
    end else if (ce) begin
      en_q   <= en;
      sel_q  <= sel;
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign commit = ce & en_q & (sel_q == SEL_CODE);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(en_q) && $stable(sel_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/pdpr_array.sv
`timescale 1ns/1ps
module pdpr_array #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];

  // R2
  commit_lands_chk: assert property (@(posedge wclk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pdpr_rd_stage.sv
`timescale 1ns/1ps
module pdpr_rd_stage #(
  parameter int DW = 8,
  parameter int AW = 11,
  parameter bit ADDR_REG = 1'b0,
  parameter bit DATA_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] data
);
  generate
    if (ADDR_REG) begin : g_addr_reg
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     addr_q <= '0;
        else if (ce) addr_q <= addr;
      end
      assign arr_addr = addr_q;

      // R6
      rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(addr_q));
    end else begin : g_addr_thru
      assign arr_addr = addr;
    end

    if (DATA_REG) begin : g_data_reg
      logic [DW-1:0] data_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     data_q <= '0;
        else if (ce) data_q <= arr_word;
      end
      assign data = data_q;

      // R6
      rd_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(data_q));
    end else begin : g_data_thru
      assign data = arr_word;
    end
  endgenerate
endmodule

// File: rtl/pdpr_top.sv
`timescale 1ns/1ps
module pdpr_top #(
  parameter int DATA_W = 8,
  parameter bit RD_ADDR_REG = 1'b0,
  parameter bit RD_DATA_REG = 1'b1,
  parameter logic [1:0] SEL_CODE = 2'b10,
  localparam int AW = pdpr_pkg::addr_bits(DATA_W)
) (
  input  logic              glob_rst,
  input  logic              loc_rst,
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_ce,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              rst;
  logic              commit;
  logic [AW-1:0]     waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [AW-1:0]     arr_raddr;
  logic [DATA_W-1:0] arr_word;

  // R1
  initial width_legal_chk: assert (pdpr_pkg::width_ok(DATA_W));

  pdpr_rst_or u_rst (
    .glob_rst (glob_rst),
    .loc_rst  (loc_rst),
    .rst      (rst)
  );

  pdpr_wr_stage #(.DW(DATA_W), .AW(AW), .SEL_CODE(SEL_CODE)) u_wr (
    .clk    (wr_clk),
    .rst    (rst),
    .ce     (wr_ce),
    .en     (wr_en),
    .sel    (wr_sel),
    .addr   (wr_addr),
    .data   (wr_data),
    .commit (commit),
    .addr_q (waddr_q),
    .data_q (wdata_q)
  );

  pdpr_array #(.DW(DATA_W), .AW(AW)) u_arr (
    .wclk  (wr_clk),
    .rst   (rst),
    .we    (commit),
    .waddr (waddr_q),
    .wdata (wdata_q),
    .raddr (arr_raddr),
    .rword (arr_word)
  );

  pdpr_rd_stage #(.DW(DATA_W), .AW(AW), .ADDR_REG(RD_ADDR_REG), .DATA_REG(RD_DATA_REG)) u_rd (
    .clk      (rd_clk),
    .rst      (rst),
    .ce       (rd_ce),
    .addr     (rd_addr),
    .arr_addr (arr_raddr),
    .arr_word (arr_word),
    .data     (rd_data)
  );
endmodule

// File: tb/sim_pdpr_top.sv
`timescale 1ns/1ps
module sim_pdpr_top;
  localparam int DW = 8;
  localparam int AW = 11;
  localparam logic [1:0] CODE = 2'b10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic glob_rst = 1'b1, loc_rst = 1'b0;
  logic wr_ce = 1'b1, wr_en = 1'b0, rd_ce = 1'b1;
  logic [1:0] wr_sel = 2'b00;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  logic w1_en = 1'b0;
  logic [8:0] w1_addr = '0, r1_addr = '0;
  logic [31:0] w1_data = '0;
  logic [31:0] r1_data;

  pdpr_top #(.DATA_W(DW)) u0 (
    .glob_rst(glob_rst), .loc_rst(loc_rst),
    .wr_clk(clk), .wr_ce(wr_ce), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_ce(rd_ce), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pdpr_top #(.DATA_W(32), .RD_ADDR_REG(1'b1), .RD_DATA_REG(1'b0)) u1 (
    .glob_rst(glob_rst), .loc_rst(loc_rst),
    .wr_clk(clk), .wr_ce(1'b1), .wr_en(w1_en), .wr_sel(CODE),
    .wr_addr(w1_addr), .wr_data(w1_data),
    .rd_clk(clk), .rd_ce(1'b1), .rd_addr(r1_addr), .rd_data(r1_data)
  );

  int total = 0, bad = 0, cycles = 0;
  logic [DW-1:0] model [0:2047];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  bit issue = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_sel = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    if (s == CODE) model[a] = d;
  endtask

  task automatic get(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    rd_addr = a; issue = 1'b1;
    exp_q.push_back(model[a]); tag_q.push_back(req);
    @(negedge clk);
    issue = 1'b0;
  endtask

  // monitor: pops one expectation for every read edge the driver armed
  always begin
    bit iss;
    @(posedge clk);
    iss = issue;
    #1;
    if (iss) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'h0, 32'h1);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check("watchdog", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 R8 reset read data", rd_data, 0);
    glob_rst = 1'b0;

    // clear the words the test touches
    for (int i = 0; i < 16; i++) put(i[AW-1:0], 8'h00, CODE);
    put(11'd2047, 8'h00, CODE);

    // R2 R11: ramp, complementary words, address ends
    for (int i = 0; i < 8; i++) put(i[AW-1:0], 8'(8'h11 * i + 3), CODE);
    put(11'd8, 8'h55, CODE);
    put(11'd9, 8'hAA, CODE);
    put(11'd10, 8'h00, CODE);
    put(11'd11, 8'hFF, CODE);
    put(11'd2047, 8'hC3, CODE);
    put(11'd0, 8'h3C, CODE);
    for (int i = 0; i < 12; i++) get(i[AW-1:0], "R2 R11");
    get(11'd2047, "R1 top address");
    get(11'd0, "R1 address zero");

    // R3 wrong select codes
    put(11'd4, 8'hE1, 2'b01);
    put(11'd4, 8'hE2, 2'b11);
    put(11'd4, 8'hE3, 2'b00);
    get(11'd4, "R3");

    // R4 enable low
    @(negedge clk);
    wr_addr = 11'd5; wr_data = 8'h99; wr_sel = CODE; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    get(11'd5, "R4");

    // R5 clock enable low
    @(negedge clk);
    wr_ce = 1'b0; wr_addr = 11'd6; wr_data = 8'h77; wr_sel = CODE; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_ce = 1'b1;
    repeat (2) @(negedge clk);
    get(11'd6, "R5");

    // R6 read clock enable low
    get(11'd8, "R6 setup");
    @(negedge clk);
    rd_ce = 1'b0; rd_addr = 11'd9;
    repeat (2) @(negedge clk);
    check("R6 read hold", rd_data, model[8]);
    rd_ce = 1'b1;

    // R7 read-before-write
    @(negedge clk);
    wr_addr = 11'd12; wr_data = 8'h5A; wr_sel = CODE; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_addr = 11'd12; issue = 1'b1;
    exp_q.push_back(model[12]); tag_q.push_back("R7 old word");
    @(negedge clk);
    exp_q.push_back(8'h5A); tag_q.push_back("R7 new word");
    model[12] = 8'h5A;
    @(negedge clk);
    issue = 1'b0;

    // R8 R9 R10 local reset drops pending write, keeps array
    @(negedge clk);
    wr_addr = 11'd7; wr_data = 8'hBD; wr_sel = CODE; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; loc_rst = 1'b1;
    #1 check("R8 R9 local reset clears read", rd_data, 0);
    @(negedge clk);
    loc_rst = 1'b0;
    get(11'd7, "R10");
    get(11'd9, "R8 array kept");

    // R9 global reset alone
    @(negedge clk);
    glob_rst = 1'b1;
    #1 check("R9 global reset clears read", rd_data, 0);
    @(negedge clk);
    glob_rst = 1'b0;
    get(11'd11, "R8 array kept after global");

    // R12 R1: 32-bit instance, registered address, pass-through data
    @(negedge clk);
    w1_addr = 9'd0; w1_data = 32'hDEAD_0001; w1_en = 1'b1;
    @(negedge clk);
    w1_addr = 9'd511; w1_data = 32'hBEEF_01FF;
    @(negedge clk);
    w1_en = 1'b0;
    @(negedge clk);
    r1_addr = 9'd511;
    @(negedge clk);
    check("R12 R1 top word", r1_data, 32'hBEEF_01FF);
    r1_addr = 9'd0;
    @(negedge clk);
    check("R12 R1 word zero", r1_data, 32'hDEAD_0001);

    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule